// File: doc/BRIEF.md
# Up/down interval timer with bus registers

This block is a counter peripheral that a processor programs through a small set of word registers. The counter steps on a clock enable taken from a power-of-two prescaler. It can count upward without stopping and wrap at a programmable ceiling. It can also count downward, reload from that ceiling and raise an underflow event. In one-shot form it halts after the first underflow. A maskable underflow flag drives a level interrupt output.

Software sets the direction, prescaler, clock source and one-shot option in the control word. It loads a start value while the timer is halted and then starts or stops the timer with separate command bits. The interrupt service routine acknowledges the flag by writing a one to the clear register. A set register lets software raise the flag on purpose, for example to test the interrupt path. Writes complete in one cycle over an address, data and write-enable bus. Reads return on a registered data port one cycle after the read strobe.

Top module: `updown_timer`

## Requirements
- R1: After reset the control word, counter, flags and enable read as 0, the ceiling (offset 0x1C) reads 0xFFFF, the timer is halted and the interrupt output is low.
- R2: With exponent p in control bits [27:24], a running timer steps once every 2^p clock cycles. The first step lands 2^p cycles after the edge that starts it.
- R3: When control bits [1:0] hold any value other than 1, each step increments the counter, and a step taken at the ceiling value gives 0. No flag is raised in this mode.
- R4: When control bits [1:0] equal 1, each step decrements the counter. A step taken at 0 loads the ceiling value and sets the underflow flag (bit 1).
- R5: When control bit 4 is set, the underflow step in down mode also halts the timer, and the counter keeps the reloaded ceiling value.
- R6: A write to offset 0x04 with bit 0 set starts the timer and one with bit 1 set halts it. When both bits are set, the timer halts.
- R7: A write to the counter at offset 0x24 loads it only while the timer is halted. While it runs, such a write has no effect.
- R8: The flag register at 0x10 is read-only. A one in bit 1 written to 0x14 sets the underflow flag and one written to 0x18 clears it. In a cycle where a clear meets a set (by software or an underflow), the flag ends up set. Every other flag bit reads 0.
- R9: The interrupt output is high exactly when the underflow flag and enable bit 1 at offset 0x0C are both set.
- R10: The read port returns a register one cycle after a read strobe. The control word reads back only its fields (bits 27:24, 17:16, 4 and 1:0), and unmapped offsets read 0.
- R11: A clock-source select in control bits [17:16] other than 0 produces no steps, so the counter holds.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, data follows one cycle later |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Underflow interrupt, level |

## Verification
A prescaler phase that drifts, or one that is not cleared when the timer halts, shows up on the first counter read-back as a count that is off by one or more steps. The same holds for an extra or missing step at the start or stop edge. A wrong reload value or a missed one-shot halt can be seen in the counter one step after the underflow. A lost flag shows up on the interrupt pin in the very next cycle. Stop-versus-start priority and the load guard are exposed by whether a later counter write is accepted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Byte offsets of the software-visible registers
   localparam int OFF_CTRL = 'h00;
   localparam int OFF_CMD  = 'h04;
   localparam int OFF_IEN  = 'h0C;
   localparam int OFF_FLAG = 'h10;
   localparam int OFF_FSET = 'h14;
   localparam int OFF_FCLR = 'h18;
   localparam int OFF_TOP  = 'h1C;
   localparam int OFF_CNT  = 'h24;

   // Bit positions inside the control and command words
   localparam int CTL_EXP_LSB = 24;
   localparam int CTL_SRC_LSB = 16;
   localparam int CTL_ONE_BIT = 4;
   localparam int CMD_GO_BIT  = 0;
   localparam int CMD_HALT_BIT = 1;
   localparam int UF_BIT      = 1;

   typedef struct packed {
      logic [3:0] exp_sel;
      logic [1:0] src_sel;
      logic       one_shot;
      logic [1:0] dir_sel;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int MAX_EXP = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] exp_i,
   output logic       tick_o
);
   generate
      if (MAX_EXP == 0) begin : g_direct
         assign tick_o = run;
      end else begin : g_div
         localparam int DIV_W = MAX_EXP;
         logic [DIV_W-1:0] phase_q;
         logic [DIV_W-1:0] mask;
         logic [3:0]       eff;

         always_comb begin
            eff  = (exp_i > 4'(MAX_EXP)) ? 4'(MAX_EXP) : exp_i;
            mask = ~({DIV_W{1'b1}} << eff);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   phase_q <= '0;
            else if (run) phase_q <= phase_q + DIV_W'(1);
            else          phase_q <= '0;
         end

         assign tick_o = run && ((phase_q & mask) == mask);

         // R2: when dividing, enables are never on adjacent cycles
         assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o && eff != 4'd0) |=> (!tick_o || eff != $past(eff)));
      end
   endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             oneshot_i,
   input  logic             down_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] top_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             running_o,
   output logic             uf_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             step;

   assign step = run_q && tick_i;
   assign uf_o = step && down_i && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   run_q <= 1'b0;
      else if (stop_i)              run_q <= 1'b0;
      else if (start_i)             run_q <= 1'b1;
      else if (uf_o && oneshot_i)   run_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_q && load_i) begin
         cnt_q <= load_val_i;
      end else if (step) begin
         if (down_i)
            cnt_q <= (cnt_q == '0) ? top_i : cnt_q - CNT_W'(1);
         else
            cnt_q <= (cnt_q == top_i) ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o     = cnt_q;
   assign running_o = run_q;

   assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick_i) |=> $stable(cnt_q));
   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o |=> (cnt_q == $past(top_i)));
   assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_o && oneshot_i && !start_i) |=> !run_q);
   assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !down_i && cnt_q == top_i) |=> (cnt_q == '0));
   assert_halt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !run_q);
endmodule

// File: rtl/updown_timer.sv
module updown_timer
   import tmr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int CNT_W   = 16,
   parameter int MAX_EXP = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [31:0]       bus_rdata,
   output logic              irq_o
);
   localparam int DATA_W = 32;

   generate
      if (ADDR_W < 6)                  begin : g_bad_addr $error("ADDR_W too small for the map"); end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt  $error("CNT_W out of range"); end
      if (MAX_EXP < 0 || MAX_EXP > 15) begin : g_bad_exp  $error("MAX_EXP must fit the 4-bit field"); end
   endgenerate

   tmr_ctrl_t        ctrl_q;
   logic             ien_q;
   logic             flag_q;
   logic [CNT_W-1:0] top_q;
   logic [CNT_W-1:0] cnt_w;
   logic             running_w, uf_w, presc_tick, step_en;
   logic             wr_ctrl, wr_cmd, wr_ien, wr_fset, wr_fclr, wr_top, wr_cnt;
   logic             go_cmd, halt_cmd;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_cmd  = bus_we && (bus_addr == ADDR_W'(OFF_CMD));
   assign wr_ien  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
   assign wr_fset = bus_we && (bus_addr == ADDR_W'(OFF_FSET));
   assign wr_fclr = bus_we && (bus_addr == ADDR_W'(OFF_FCLR));
   assign wr_top  = bus_we && (bus_addr == ADDR_W'(OFF_TOP));
   assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(OFF_CNT));

   assign go_cmd   = wr_cmd && bus_wdata[CMD_GO_BIT];
   assign halt_cmd = wr_cmd && bus_wdata[CMD_HALT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= 1'b0;
         top_q  <= '1;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.exp_sel  <= bus_wdata[CTL_EXP_LSB +: 4];
            ctrl_q.src_sel  <= bus_wdata[CTL_SRC_LSB +: 2];
            ctrl_q.one_shot <= bus_wdata[CTL_ONE_BIT];
            ctrl_q.dir_sel  <= bus_wdata[1:0];
         end
         if (wr_ien) ien_q <= bus_wdata[UF_BIT];
         if (wr_top) top_q <= bus_wdata[CNT_W-1:0];
      end
   end

   // Clear is applied first, then any set source
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q && !(wr_fclr && bus_wdata[UF_BIT]))
                            || (wr_fset && bus_wdata[UF_BIT]) || uf_w;
   end

   tmr_prescaler #(.MAX_EXP(MAX_EXP)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (running_w),
      .exp_i  (ctrl_q.exp_sel),
      .tick_o (presc_tick)
   );

   assign step_en = presc_tick && (ctrl_q.src_sel == 2'd0);

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (go_cmd),
      .stop_i     (halt_cmd),
      .oneshot_i  (ctrl_q.one_shot),
      .down_i     (ctrl_q.dir_sel == 2'd1),
      .tick_i     (step_en),
      .top_i      (top_q),
      .load_i     (wr_cnt),
      .load_val_i (bus_wdata[CNT_W-1:0]),
      .cnt_o      (cnt_w),
      .running_o  (running_w),
      .uf_o       (uf_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_re) begin
         bus_rdata <= '0;
         case (int'(bus_addr))
            OFF_CTRL: begin
               bus_rdata[CTL_EXP_LSB +: 4] <= ctrl_q.exp_sel;
               bus_rdata[CTL_SRC_LSB +: 2] <= ctrl_q.src_sel;
               bus_rdata[CTL_ONE_BIT]      <= ctrl_q.one_shot;
               bus_rdata[1:0]              <= ctrl_q.dir_sel;
            end
            OFF_IEN:  bus_rdata[UF_BIT] <= ien_q;
            OFF_FLAG: bus_rdata[UF_BIT] <= flag_q;
            OFF_TOP:  bus_rdata <= DATA_W'(top_q);
            OFF_CNT:  bus_rdata <= DATA_W'(cnt_w);
            default:  bus_rdata <= '0;
         endcase
      end
   end

   assign irq_o = flag_q && ien_q;

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uf_w |=> flag_q);
   assert_flag_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!uf_w && !wr_fset && !wr_fclr) |=> $stable(flag_q));
endmodule

// File: tb/test_updown_timer.sv
module test_updown_timer;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WD_CYCLES  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updown_timer i_updown_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   // Reference stepping of the counter, written from R3..R5
   function automatic void model(input bit down, input bit os, input logic [15:0] top,
                                 inout logic [15:0] c, inout bit f, input int n);
      bit halted = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (!halted) begin
            if (down) begin
               if (c == 16'd0) begin
                  c = top; f = 1'b1;
                  if (os) halted = 1'b1;
               end else c = c - 16'd1;
            end else c = (c == top) ? 16'd0 : c + 16'd1;
         end
      end
   endfunction

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] v;
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
      rd(8'h1C, v); chk("R1 top", v, 32'hFFFF);
      rd(8'h24, v); chk("R1 cnt", v, 32'h0);
      rd(8'h10, v); chk("R1 flag", v, 32'h0);
      rd(8'h0C, v); chk("R1 ien", v, 32'h0);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);

      // R10 control field readback, unmapped read
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R10 ctrl fields", v, 32'h0F03_0013);
      rd(8'h08, v); chk("R10 unmapped", v, 32'h0);
      wr(8'h00, 32'h0);

      // R6 halt wins over start
      wr(8'h24, 32'd5);
      wr(8'h04, 32'h3);
      repeat (5) @(negedge clk);
      rd(8'h24, v); chk("R6 no count", v, 32'd5);
      wr(8'h24, 32'd9);
      rd(8'h24, v); chk("R6 halted accepts load", v, 32'd9);

      // R7 load ignored while running: steps at the two following edges
      wr(8'h24, 32'd0);
      wr(8'h04, 32'h1);
      wr(8'h24, 32'h1234);
      wr(8'h04, 32'h2);
      rd(8'h24, v); chk("R7 load ignored", v, 32'd2);

      // R2 prescaler divide by 1024
      wr(8'h00, 32'h0A00_0000);
      wr(8'h24, 32'd0);
      wr(8'h04, 32'h1);
      repeat (2047) @(negedge clk);
      wr(8'h04, 32'h2);
      rd(8'h24, v); chk("R2 div1024 two steps", v, 32'd2);
      wr(8'h24, 32'd0);
      wr(8'h04, 32'h1);
      repeat (1022) @(negedge clk);
      wr(8'h04, 32'h2);
      rd(8'h24, v); chk("R2 div1024 before first step", v, 32'd0);

      // R11 non-zero clock source gives no steps
      wr(8'h00, 32'h0001_0000);
      wr(8'h24, 32'd7);
      wr(8'h04, 32'h1);
      repeat (10) @(negedge clk);
      wr(8'h04, 32'h2);
      rd(8'h24, v); chk("R11 holds", v, 32'd7);

      // R3 directed wrap: 2->3->0->1->2
      wr(8'h00, 32'h0);
      wr(8'h1C, 32'd3);
      wr(8'h24, 32'd2);
      wr(8'h04, 32'h1);
      repeat (3) @(negedge clk);
      wr(8'h04, 32'h2);
      rd(8'h24, v); chk("R3 wrap", v, 32'd2);
      rd(8'h10, v); chk("R3 no flag", v, 32'd0);

      // R8 / R9 flag set, clear and masking
      wr(8'h14, 32'h2);
      rd(8'h10, v); chk("R8 set", v, 32'h2);
      chk("R9 masked", {31'b0, irq_o}, 32'h0);
      wr(8'h0C, 32'h2);
      chk("R9 irq high", {31'b0, irq_o}, 32'h1);
      rd(8'h0C, v); chk("R9 ien read", v, 32'h2);
      wr(8'h18, 32'h2);
      rd(8'h10, v); chk("R8 clear", v, 32'h0);
      chk("R9 irq low", {31'b0, irq_o}, 32'h0);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h10, v); chk("R8 other bits zero", v, 32'h2);
      wr(8'h10, 32'h0);
      rd(8'h10, v); chk("R8 flag read-only", v, 32'h2);
      wr(8'h18, 32'h2);

      // R4/R5/R8: one-shot underflow on the same edge as a clear
      wr(8'h00, 32'h0000_0011);
      wr(8'h1C, 32'd20);
      wr(8'h24, 32'd1);
      wr(8'h04, 32'h1);
      @(negedge clk);
      wr(8'h18, 32'h2);
      wr(8'h04, 32'h2);
      rd(8'h10, v); chk("R8 set wins over clear", v, 32'h2);
      rd(8'h24, v); chk("R4 R5 reload and halt", v, 32'd20);
      chk("R9 irq on underflow", {31'b0, irq_o}, 32'h1);
      wr(8'h24, 32'd4);
      rd(8'h24, v); chk("R5 halted after one-shot", v, 32'd4);
      wr(8'h18, 32'h2);
      wr(8'h0C, 32'h0);

      // Random runs against the reference model (R2, R3, R4, R5)
      for (int it = 0; it < 24; it++) begin
         int unsigned mode, p, k;
         bit down, os, f;
         logic [15:0] top, c;
         mode = $urandom_range(0, 2);
         down = (mode == 1);
         os   = down ? 1'($urandom_range(0, 1)) : 1'b0;
         top  = 16'($urandom_range(3, 40));
         p    = $urandom_range(0, 3);
         c    = 16'($urandom_range(0, int'(top)));
         k    = $urandom_range(0, 60);
         wr(8'h00, (p << 24) | (32'(os) << 4) | mode);
         wr(8'h1C, 32'(top));
         wr(8'h24, 32'(c));
         wr(8'h18, 32'h2);
         wr(8'h04, 32'h1);
         repeat (k) @(negedge clk);
         wr(8'h04, 32'h2);
         f = 1'b0;
         model(down, os, top, c, f, int'((k + 1) >> p));
         rd(8'h24, v); chk("R2 R3 R4 R5 random count", v, 32'(c));
         rd(8'h10, v); chk("R4 random flag", v, {30'b0, f, 1'b0});
      end

      summary();
   end
endmodule